// File: doc/BRIEF.md
# Colormap Pixel Formatter with Queued Colormap Updates

This block turns a stream of raw pixels into 24-bit RGB. Each pixel arrives with a two-bit format code. An 8-bit index selects a colour from a 256-entry colormap. A 16-bit word carries three 5-bit channels. A 32-bit word carries three 8-bit channels and an alpha byte, and the alpha byte is discarded. After decoding, each channel goes through its own 256-entry gamma table. The result comes out two clocks after the pixel was accepted.

Host writes share one port, and a select bit picks the target. Gamma writes take effect at once. Colormap writes go into a 64-entry queue. The queue empties into the colormap one entry per clock, and only while the colormap window input is high. The display side raises that window during blanking, so a colour never changes halfway through a visible line. The queue occupancy is always visible, so software can hold back before the queue fills. A write that finds the queue full is dropped and latches a sticky overflow flag.

Top module: `rgb_pixel_formatter`

## Requirements
- R1: After reset the output is not valid, the queue level is 0 and the overflow flag is 0. Every colormap entry is zero. Every gamma entry holds its own address, so the gamma tables pass values through unchanged.
- R2: Format code 0 is indexed. The colormap entry selected by pix_data[7:0] supplies red, green and blue.
- R3: Format code 1 is the 16-bit format, with blue in pix_data[4:0], green in [9:5] and red in [14:10]. Bit 15 is ignored. Each 5-bit value v widens to 8 bits as {v, v[4:2]}.
- R4: Format code 2 takes blue from pix_data[15:8], green from [23:16] and red from [31:24]. Bits [7:0] are alpha and have no effect. Format code 3 decodes to zero on all three channels.
- R5: Each decoded channel is replaced by the entry of that channel's gamma table at the channel value. A host write with wr_sel=1 stores wr_data[31:24], [23:16] and [15:8] into the red, green and blue gamma tables at wr_addr. Pixels that arrive after the write see the new entries.
- R6: out_valid rises exactly two clocks after a pixel is accepted with pix_valid, and out_rgb holds red in [23:16], green in [15:8] and blue in [7:0].
- R7: A colormap write (wr_sel=0) is queued and does not reach the colormap while cmap_window is low. While cmap_window is high, one queued entry per clock is written to the colormap. An indexed pixel accepted in the same clock that its entry is written gets the old colour. The next pixel gets the new colour.
- R8: Colormap words use the same byte layout as gamma words, with wr_data[7:0] unused. Queued entries reach the colormap in the order they were written, so the last write to an index wins.
- R9: A colormap write that arrives while the level is 64 is dropped and sets cmap_overflow. The flag stays set until reset.
- R10: cmap_level equals the number of queued entries. A write together with a drain in the same clock leaves the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel present this clock |
| pix_mode | input | 2 | Format code: 0 indexed, 1 16-bit, 2 32-bit, 3 reserved |
| pix_data | input | 32 | Raw pixel word |
| wr_en | input | 1 | Host table write strobe |
| wr_sel | input | 1 | Write target: 0 colormap queue, 1 gamma tables |
| wr_addr | input | 8 | Table entry address |
| wr_data | input | 32 | Entry word: red [31:24], green [23:16], blue [15:8] |
| cmap_window | input | 1 | Allows the queue to drain into the colormap |
| cmap_level | output | 7 | Number of queued colormap writes |
| cmap_overflow | output | 1 | Sticky flag for a dropped colormap write |
| out_valid | output | 1 | Formatted pixel present |
| out_rgb | output | 24 | Formatted colour: red [23:16], green [15:8], blue [7:0] |

## Verification
Two functions can meet in the same clock: a colormap entry drains from the queue while an indexed pixel reads that same entry. The bench queues a single entry with the window low. In one clock it then raises the window and presents a pixel with that index. It expects the old colour for that pixel and the new colour for the next one. It also combines a queued write with a drain in one clock and checks that the level holds, and it fills the queue to force a drop. The checks on R9 confirm that the dropped index keeps its old colour.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;

   typedef enum logic [1:0] {
      PM_INDEX  = 2'd0,
      PM_RGB15  = 2'd1,
      PM_RGBA32 = 2'd2,
      PM_RSVD   = 2'd3
   } pix_mode_e;

   typedef struct packed {
      logic [7:0] r;
      logic [7:0] g;
      logic [7:0] b;
   } rgb_t;

   function automatic logic [7:0] widen5(input logic [4:0] v);
      return {v, v[4:2]};
   endfunction

endpackage

// File: rtl/cmap_wr_fifo.sv
module cmap_wr_fifo #(
   parameter int DEPTH = 64,
   parameter int ENT_W = 32,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [ENT_W-1:0] push_data,
   input  logic             pop_en,
   output logic             pop_valid,
   output logic [ENT_W-1:0] pop_data,
   output logic [LVL_W-1:0] level,
   output logic             overflow
);

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $fatal(1, "cmap_wr_fifo: DEPTH must be a power of two");
   end

   logic [ENT_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [LVL_W-1:0] cnt;
   logic             ovf_q;
   logic             full, accept, take;

   assign full   = (cnt == LVL_W'(DEPTH));
   assign accept = push && !full;
   assign take   = pop_en && (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
         ovf_q  <= 1'b0;
      end else begin
         if (accept) wr_ptr <= wr_ptr + 1'b1;
         if (take)   rd_ptr <= rd_ptr + 1'b1;
         case ({accept, take})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
         if (push && full) ovf_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (accept) mem[wr_ptr] <= push_data;
   end

   assign pop_valid = take;
   assign pop_data  = mem[rd_ptr];
   assign level     = cnt;
   assign overflow  = ovf_q;

   // R10
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LVL_W'(DEPTH));
   // R10
   level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full && !pop_en) |=> (cnt == $past(cnt) + 1'b1));
   // R7
   no_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pop_en |=> (cnt >= $past(cnt)));
   // R9
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop_en) |=> (ovf_q && cnt == $past(cnt)));
   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
   import pixfmt_pkg::*;
#(
   parameter int IDX_W = 8,
   localparam int ENTRIES = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_valid,
   input  logic [1:0]       pix_mode,
   input  logic [31:0]      pix_data,
   input  logic             cm_we,
   input  logic [IDX_W-1:0] cm_addr,
   input  logic [23:0]      cm_rgb,
   output logic             s1_valid,
   output logic [23:0]      s1_rgb
);

   rgb_t cmap [ENTRIES];
   rgb_t dec;
   rgb_t s1_q;
   logic v_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) cmap[i] <= '0;
      end else if (cm_we) begin
         cmap[cm_addr] <= rgb_t'(cm_rgb);
      end
   end

   always_comb begin
      case (pix_mode_e'(pix_mode))
         PM_INDEX:  dec = cmap[pix_data[IDX_W-1:0]];
         PM_RGB15:  dec = '{r: widen5(pix_data[14:10]),
                           g: widen5(pix_data[9:5]),
                           b: widen5(pix_data[4:0])};
         PM_RGBA32: dec = '{r: pix_data[31:24],
                           g: pix_data[23:16],
                           b: pix_data[15:8]};
         default:   dec = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q  <= 1'b0;
         s1_q <= '0;
      end else begin
         v_q <= pix_valid;
         if (pix_valid) s1_q <= dec;
      end
   end

   assign s1_valid = v_q;
   assign s1_rgb   = s1_q;

   // R6
   s1_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> v_q);

endmodule

// File: rtl/gamma_stage.sv
module gamma_stage #(
   parameter bit GAMMA_EN = 1'b1,
   parameter int CH_W     = 8,
   localparam int LUT_N   = 1 << CH_W,
   localparam int WORD_W  = 3 * CH_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gw_en,
   input  logic [CH_W-1:0]   gw_addr,
   input  logic [WORD_W-1:0] gw_word,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_word
);

   logic [CH_W-1:0]   chan_out [3];
   logic [WORD_W-1:0] q;
   logic              v_q;

   if (GAMMA_EN) begin : g_lut
      for (genvar ch = 0; ch < 3; ch++) begin : g_ch
         logic [CH_W-1:0] lut [LUT_N];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < LUT_N; i++) lut[i] <= CH_W'(i);
            end else if (gw_en) begin
               lut[gw_addr] <= gw_word[CH_W*ch +: CH_W];
            end
         end
         assign chan_out[ch] = lut[in_word[CH_W*ch +: CH_W]];
      end
   end else begin : g_bypass
      logic unused_gw;
      assign unused_gw = ^{gw_en, gw_addr, gw_word};
      for (genvar ch = 0; ch < 3; ch++) begin : g_ch
         assign chan_out[ch] = in_word[CH_W*ch +: CH_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= 1'b0;
         q   <= '0;
      end else begin
         v_q <= in_valid;
         if (in_valid) q <= {chan_out[2], chan_out[1], chan_out[0]};
      end
   end

   assign out_valid = v_q;
   assign out_word  = q;

   // R6
   gam_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> v_q);
   // R6
   gam_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !v_q);

endmodule

// File: rtl/rgb_pixel_formatter.sv
module rgb_pixel_formatter #(
   parameter int FIFO_DEPTH = 64,
   parameter int IDX_W      = 8,
   parameter bit GAMMA_EN   = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              pix_valid,
   input  logic [1:0]                        pix_mode,
   input  logic [31:0]                       pix_data,
   input  logic                              wr_en,
   input  logic                              wr_sel,
   input  logic [7:0]                        wr_addr,
   input  logic [31:0]                       wr_data,
   input  logic                              cmap_window,
   output logic [$clog2(FIFO_DEPTH+1)-1:0]   cmap_level,
   output logic                              cmap_overflow,
   output logic                              out_valid,
   output logic [23:0]                       out_rgb
);

   localparam int ENT_W = IDX_W + 24;

   initial begin
      assert (IDX_W >= 1 && IDX_W <= 8)
         else $fatal(1, "rgb_pixel_formatter: IDX_W out of range");
   end

   logic             q_push, g_we;
   logic             cm_we;
   logic [ENT_W-1:0] cm_ent;
   logic             s1_valid;
   logic [23:0]      s1_rgb;
   logic             unused_wr;

   assign q_push    = wr_en && !wr_sel;
   assign g_we      = wr_en && wr_sel;
   assign unused_wr = ^wr_data[7:0];

   cmap_wr_fifo #(.DEPTH(FIFO_DEPTH), .ENT_W(ENT_W)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push),
      .push_data ({wr_addr[IDX_W-1:0], wr_data[31:8]}),
      .pop_en    (cmap_window),
      .pop_valid (cm_we),
      .pop_data  (cm_ent),
      .level     (cmap_level),
      .overflow  (cmap_overflow)
   );

   pix_unpack #(.IDX_W(IDX_W)) u_unpack (
      .clk       (clk),
      .rst_n     (rst_n),
      .pix_valid (pix_valid),
      .pix_mode  (pix_mode),
      .pix_data  (pix_data),
      .cm_we     (cm_we),
      .cm_addr   (cm_ent[ENT_W-1 -: IDX_W]),
      .cm_rgb    (cm_ent[23:0]),
      .s1_valid  (s1_valid),
      .s1_rgb    (s1_rgb)
   );

   gamma_stage #(.GAMMA_EN(GAMMA_EN), .CH_W(8)) u_gamma (
      .clk       (clk),
      .rst_n     (rst_n),
      .gw_en     (g_we),
      .gw_addr   (wr_addr),
      .gw_word   (wr_data[31:8]),
      .in_valid  (s1_valid),
      .in_word   (s1_rgb),
      .out_valid (out_valid),
      .out_word  (out_rgb)
   );

   // R9
   top_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_push && !cmap_window && cmap_level == $bits(cmap_level)'(FIFO_DEPTH))
      |=> cmap_overflow);

endmodule

// File: tb/rgb_pixel_formatter_test.sv
`timescale 1ns/1ps
module rgb_pixel_formatter_test;

   localparam int DEPTH = 64;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        pix_valid;
   logic [1:0]  pix_mode;
   logic [31:0] pix_data;
   logic        wr_en, wr_sel;
   logic [7:0]  wr_addr;
   logic [31:0] wr_data;
   logic        cmap_window;
   logic [6:0]  cmap_level;
   logic        cmap_overflow;
   logic        out_valid;
   logic [23:0] out_rgb;

   always #2.5 clk = ~clk;

   rgb_pixel_formatter uut (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_mode(pix_mode),
      .pix_data(pix_data), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
      .wr_data(wr_data), .cmap_window(cmap_window), .cmap_level(cmap_level),
      .cmap_overflow(cmap_overflow), .out_valid(out_valid), .out_rgb(out_rgb)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   logic [23:0] m_cmap [256];
   logic [7:0]  m_gam [3][256];
   logic [7:0]  q_addr [$];
   logic [23:0] q_data [$];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] w5(input logic [4:0] v);
      return {v, v[4:2]};
   endfunction

   function automatic logic [23:0] exp_pix(input logic [1:0] m, input logic [31:0] d);
      logic [7:0] r, g, b;
      case (m)
         2'd0: {r, g, b} = m_cmap[d[7:0]];
         2'd1: begin r = w5(d[14:10]); g = w5(d[9:5]); b = w5(d[4:0]); end
         2'd2: begin r = d[31:24]; g = d[23:16]; b = d[15:8]; end
         default: begin r = 8'h0; g = 8'h0; b = 8'h0; end
      endcase
      return {m_gam[2][r], m_gam[1][g], m_gam[0][b]};
   endfunction

   task automatic send_pix(input string req, input logic [1:0] m, input logic [31:0] d);
      logic [23:0] e;
      e = exp_pix(m, d);
      @(negedge clk);
      pix_valid = 1'b1; pix_mode = m; pix_data = d;
      @(negedge clk);
      pix_valid = 1'b0;
      @(negedge clk);
      chk({req, " valid"}, 32'(out_valid), 32'd1);
      chk({req, " rgb"}, 32'(out_rgb), 32'(e));
   endtask

   task automatic host_wr(input bit sel, input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (sel) begin
         m_gam[2][a] = d[31:24]; m_gam[1][a] = d[23:16]; m_gam[0][a] = d[15:8];
      end else if (q_addr.size() < DEPTH) begin
         q_addr.push_back(a); q_data.push_back(d[31:8]);
      end
   endtask

   task automatic drain(input int n);
      @(negedge clk);
      cmap_window = 1'b1;
      repeat (n) @(negedge clk);
      cmap_window = 1'b0;
      for (int i = 0; i < n && q_addr.size() > 0; i++)
         m_cmap[q_addr.pop_front()] = q_data.pop_front();
   endtask

   initial begin
      #900us;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [23:0] old_c;
      void'($urandom(32'h5eed_0042));
      for (int i = 0; i < 256; i++) begin
         m_cmap[i] = '0;
         for (int c = 0; c < 3; c++) m_gam[c][i] = 8'(i);
      end
      rst_n = 1'b0; pix_valid = 0; pix_mode = 0; pix_data = 0;
      wr_en = 0; wr_sel = 0; wr_addr = 0; wr_data = 0; cmap_window = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 out_valid", 32'(out_valid), 0);
      chk("R1 level", 32'(cmap_level), 0);
      chk("R1 overflow", 32'(cmap_overflow), 0);
      send_pix("R1 cmap zero", 2'd0, 32'h05);
      send_pix("R1 gamma identity", 2'd2, 32'h12345678);

      // R3 16-bit format, bit 15 ignored
      send_pix("R3 red", 2'd1, 32'h7C00);
      send_pix("R3 bit15", 2'd1, 32'h8421);
      send_pix("R3 mix", 2'd1, 32'h03E5);
      // R4 32-bit format, alpha ignored, reserved code
      send_pix("R4 alpha a", 2'd2, 32'hA0B0C000);
      send_pix("R4 alpha b", 2'd2, 32'hA0B0C0FF);
      send_pix("R4 reserved", 2'd3, 32'hFFFFFFFF);

      // R7 queued write invisible while window low
      host_wr(1'b0, 8'h10, 32'h11223344);
      chk("R10 level one", 32'(cmap_level), 1);
      m_cmap[8'h10] = 24'h0; // not yet applied
      send_pix("R7 not drained", 2'd0, 32'h10);
      drain(1);
      chk("R10 level drained", 32'(cmap_level), 0);
      send_pix("R2 indexed", 2'd0, 32'hFFFFFF10);

      // R8 order: later write to same index wins
      host_wr(1'b0, 8'h20, 32'hAAAAAA00);
      host_wr(1'b0, 8'h20, 32'h55667700);
      drain(2);
      send_pix("R8 last wins", 2'd0, 32'h20);

      // R5 gamma write immediate
      host_wr(1'b1, 8'hAA, 32'h11223300);
      send_pix("R5 gamma", 2'd2, 32'hAAAAAA99);
      host_wr(1'b1, 8'h08, 32'h80818200);
      send_pix("R5 gamma on 16-bit", 2'd1, 32'h0421);

      // R7 drain and lookup of the same entry in one clock
      host_wr(1'b0, 8'h33, 32'hC0C1C200);
      old_c = exp_pix(2'd0, 32'h33);
      @(negedge clk);
      cmap_window = 1'b1; pix_valid = 1'b1; pix_mode = 2'd0; pix_data = 32'h33;
      @(negedge clk);
      cmap_window = 1'b0; pix_valid = 1'b0;
      m_cmap[q_addr.pop_front()] = q_data.pop_front();
      @(negedge clk);
      chk("R7 same clock old", 32'(out_rgb), 32'(old_c));
      send_pix("R7 next gets new", 2'd0, 32'h33);

      // R10 write plus drain in one clock keeps level
      host_wr(1'b0, 8'h40, 32'h01020300);
      host_wr(1'b0, 8'h41, 32'h04050600);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 1'b0; wr_addr = 8'h42; wr_data = 32'h07080900;
      cmap_window = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; cmap_window = 1'b0;
      m_cmap[q_addr.pop_front()] = q_data.pop_front();
      q_addr.push_back(8'h42); q_data.push_back(24'h070809);
      chk("R10 simultaneous", 32'(cmap_level), 2);
      drain(4);
      send_pix("R10 drained 41", 2'd0, 32'h41);
      send_pix("R10 drained 42", 2'd0, 32'h42);

      // R9 full queue drops and latches flag
      for (int i = 0; i < DEPTH; i++) host_wr(1'b0, 8'(i), {8'(i), 8'h5A, 8'(~i), 8'h0});
      chk("R9 level full", 32'(cmap_level), DEPTH);
      chk("R9 no overflow yet", 32'(cmap_overflow), 0);
      host_wr(1'b0, 8'hEE, 32'hDEADBE00);
      chk("R9 level held", 32'(cmap_level), DEPTH);
      chk("R9 overflow", 32'(cmap_overflow), 1);
      drain(DEPTH + 4);
      chk("R9 level empty", 32'(cmap_level), 0);
      chk("R9 sticky", 32'(cmap_overflow), 1);
      send_pix("R9 dropped index", 2'd0, 32'hEE);
      send_pix("R9 last kept", 2'd0, 32'h3F);

      // Random mix
      for (int it = 0; it < 400; it++) begin
         int sel;
         sel = int'($urandom_range(0, 9));
         if (sel < 6) begin
            send_pix("R2 R3 R4 R5 random", 2'($urandom_range(0, 3)), $urandom());
         end else if (sel < 8) begin
            if ($urandom_range(0, 1) == 1)
               host_wr(1'b1, 8'($urandom()), $urandom());
            else if (q_addr.size() < DEPTH)
               host_wr(1'b0, 8'($urandom()), $urandom());
            chk("R10 random level", 32'(cmap_level), q_addr.size());
         end else begin
            drain(int'($urandom_range(1, 4)));
            chk("R7 random level", 32'(cmap_level), q_addr.size());
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule